// File: doc/BRIEF.md
# Polled Byte Serial Port

This block is a byte-wide asynchronous serial transceiver that sits on a small host bus and is run by polling. There are four byte locations on the bus. One is the data location. A write there sends a byte on the transmit pin. A read there returns the byte most recently received and marks it as consumed. The second location is a combined control and status byte. Through it the host switches the port on, picks one of two bit rates, clears a sticky overrun flag, and polls the receive and transmit state. The remaining two locations hold an interrupt mask and an interrupt vector base.

The line format is fixed: one start bit, eight data bits sent least significant bit first, and one stop bit. There is no parity and no handshaking. The bit timing is derived from the `CLK_HZ` parameter. The receiver oversamples at sixteen times the bit rate, checks the middle of the start bit, and takes each data bit at the centre of its cell. While a received byte is waiting and its mask bit is set, the block raises an interrupt request and presents a vector number equal to the programmed base plus three.

Top module: `byte_serial_port`

## Requirements
- R1: After reset the transmit pin is high, `irqReq` is low, and a read of the status location (address 1) returns 0x00.
- R2: While the enable bit (bit 7 of the control byte at address 1) is clear, a read of address 1 returns 0x00, even when received data or an overrun is pending.
- R3: While the port is enabled, a read of address 1 returns bit 7 = 1, bit 6 = the selected rate, bits 5..3 = 0, bit 2 = transmitter idle, bit 1 = overrun, and bit 0 = received byte waiting.
- R4: A write to address 0 while enabled and idle sends a frame on `serOut`: a low start bit, the eight data bits LSB first, and a high stop bit. Each bit lasts CLK_HZ/9600 clocks when control bit 6 is 0 and CLK_HZ/38400 clocks when it is 1.
- R5: A write to address 0 while a frame is in progress is ignored, so no second frame follows. Status bit 2 reads 0 during a frame and returns to 1 once the stop bit ends.
- R6: A complete received frame sets status bit 0. A read of address 0 returns the received byte and clears bit 0.
- R7: A frame that completes while bit 0 is still set sets status bit 1 and is discarded, and the held byte keeps its earlier value.
- R8: A write to address 1 with bit 5 set clears the overrun flag (status bit 1).
- R9: A low pulse on `serIn` shorter than half a bit time is rejected as a false start and sets no status bit.
- R10: `irqReq` is high exactly while the port is enabled, a byte is waiting, and bit 2 of the mask register (address 2) is set. `irqVector` equals the base register (address 3) plus 3, modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 2 | Location: 0 data, 1 control/status, 2 interrupt mask, 3 vector base |
| busWr | input | 1 | Write strobe, one clock per access |
| busRd | input | 1 | Read strobe; at address 0 it consumes the waiting byte |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from `busAddr` |
| serIn | input | 1 | Serial receive line, idle high |
| serOut | output | 1 | Serial transmit line, idle high |
| irqReq | output | 1 | Receive interrupt request |
| irqVector | output | 8 | Interrupt vector number |

## Verification
The hardest state to reach from the pins is an overrun. A second complete frame has to land while the first byte is still unread, and the bench must then confirm that the held byte survives while the flag sets. The bench gets there by driving two back-to-back frames onto `serIn` without any read in between. It then checks the status, pops the byte, and clears the flag with a control write. False-start rejection is reached with a low glitch timed to end before the mid-start sample point. The test then checks that a correct frame sent after the glitch is still received.

// File: rtl/serport_pkg.sv
package serport_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_MASK = 2'd2;
  localparam logic [1:0] ADDR_BASE = 2'd3;

  // control -> datapath strobes
  typedef struct packed {
    logic       portEn;
    logic       fastRate;
    logic       txLoad;
    logic [7:0] txByte;
  } serStrb_t;
endpackage

// File: rtl/serport_dp.sv
module serport_dp
  import serport_pkg::*;
#(
  parameter int CLK_HZ    = 125_000_000,
  parameter int SLOW_BAUD = 9600,
  parameter int FAST_BAUD = 38400
) (
  input  logic       clk,
  input  logic       rst,
  input  serStrb_t   strb,
  input  logic       serIn,
  output logic       serOut,
  output logic       txBusy,
  output logic       rxDone,
  output logic [7:0] rxByte
);
  localparam int SLOW_DIV = CLK_HZ / (SLOW_BAUD * 16);
  localparam int FAST_DIV = CLK_HZ / (FAST_BAUD * 16);
  localparam int DIV_W    = $clog2(SLOW_DIV + 1);
  localparam logic [DIV_W-1:0] SLOW_LIM = DIV_W'(SLOW_DIV - 1);
  localparam logic [DIV_W-1:0] FAST_LIM = DIV_W'(FAST_DIV - 1);

  // oversample tick
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLim;
  logic             tick;
  assign divLim = strb.fastRate ? FAST_LIM : SLOW_LIM;
  assign tick   = strb.portEn && (divCnt >= divLim);

  always_ff @(posedge clk) begin
    if (rst || !strb.portEn || tick) divCnt <= '0;
    else                             divCnt <= divCnt + 1'b1;
  end

  // transmitter
  logic [9:0] txSh;
  logic [3:0] txSub;
  logic [3:0] txBits;

  always_ff @(posedge clk) begin
    if (rst) begin
      txSh   <= '1;
      txBusy <= 1'b0;
      txSub  <= '0;
      txBits <= '0;
    end else if (!txBusy) begin
      if (strb.txLoad) begin
        txSh   <= {1'b1, strb.txByte, 1'b0};
        txBusy <= 1'b1;
        txSub  <= '0;
        txBits <= '0;
      end
    end else if (!strb.portEn) begin
      txSh   <= '1;
      txBusy <= 1'b0;
    end else if (tick) begin
      txSub <= txSub + 1'b1;
      if (txSub == 4'd15) begin
        txSh   <= {1'b1, txSh[9:1]};
        txBits <= txBits + 1'b1;
        if (txBits == 4'd9) txBusy <= 1'b0;
      end
    end
  end

  assign serOut = txBusy ? txSh[0] : 1'b1;

  // receiver
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_t;
  rxState_t   rxState;
  logic       rxMeta, rxSync;
  logic [7:0] rxSh;
  logic [3:0] rxSub;
  logic [2:0] rxBits;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= serIn;
      rxSync <= rxMeta;
    end
  end

  always_ff @(posedge clk) begin
    rxDone <= 1'b0;
    if (rst || !strb.portEn) begin
      rxState <= RX_IDLE;
      rxSh    <= '0;
      rxSub   <= '0;
      rxBits  <= '0;
    end else begin
      case (rxState)
        RX_IDLE: if (!rxSync) begin
          rxState <= RX_START;
          rxSub   <= '0;
        end
        RX_START: if (tick) begin
          rxSub <= rxSub + 1'b1;
          if (rxSub == 4'd7) begin
            rxSub   <= '0;
            rxBits  <= '0;
            rxState <= rxSync ? RX_IDLE : RX_DATA;
          end
        end
        RX_DATA: if (tick) begin
          rxSub <= rxSub + 1'b1;
          if (rxSub == 4'd15) begin
            rxSh   <= {rxSync, rxSh[7:1]};
            rxBits <= rxBits + 1'b1;
            if (rxBits == 3'd7) rxState <= RX_STOP;
          end
        end
        RX_STOP: if (tick) begin
          rxSub <= rxSub + 1'b1;
          if (rxSub == 4'd15) begin
            rxDone  <= rxSync;
            rxState <= RX_IDLE;
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  assign rxByte = rxSh;
endmodule

// File: rtl/serport_ctrl.sv
module serport_ctrl
  import serport_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic       rxDone,
  input  logic [7:0] rxByte,
  input  logic       txBusy,
  output serStrb_t   strb,
  output logic       irqReq,
  output logic [7:0] irqVector
);
  logic       portEn, fastRate, dataAvail, overrun;
  logic [7:0] irqMask, vecBase, rxHold;
  logic       popRx, wrCtrl;

  assign popRx  = busRd && (busAddr == ADDR_DATA);
  assign wrCtrl = busWr && (busAddr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      portEn    <= 1'b0;
      fastRate  <= 1'b0;
      irqMask   <= '0;
      vecBase   <= '0;
    end else if (busWr) begin
      case (busAddr)
        ADDR_CTRL: begin
          portEn   <= busWrData[7];
          fastRate <= busWrData[6];
        end
        ADDR_MASK: irqMask <= busWrData;
        ADDR_BASE: vecBase <= busWrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxHold    <= '0;
      dataAvail <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (wrCtrl && busWrData[5]) overrun <= 1'b0;
      if (rxDone) begin
        if (dataAvail && !popRx) overrun <= 1'b1;
        else begin
          rxHold    <= rxByte;
          dataAvail <= 1'b1;
        end
      end else if (popRx) begin
        dataAvail <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.portEn   = portEn;
    strb.fastRate = fastRate;
    strb.txLoad   = busWr && (busAddr == ADDR_DATA) && portEn && !txBusy;
    strb.txByte   = busWrData;
  end

  always_comb begin
    case (busAddr)
      ADDR_DATA: busRdData = rxHold;
      ADDR_CTRL: busRdData = portEn ? {1'b1, fastRate, 3'b000, !txBusy, overrun, dataAvail} : 8'h00;
      ADDR_MASK: busRdData = irqMask;
      default:   busRdData = vecBase;
    endcase
  end

  assign irqReq    = portEn && dataAvail && irqMask[2];
  assign irqVector = vecBase + 8'd3;
endmodule

// File: rtl/byte_serial_port.sv
module byte_serial_port
  import serport_pkg::*;
#(
  parameter int CLK_HZ    = 125_000_000,
  parameter int SLOW_BAUD = 9600,
  parameter int FAST_BAUD = 38400
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic       serIn,
  output logic       serOut,
  output logic       irqReq,
  output logic [7:0] irqVector
);
  serStrb_t   strb;
  logic       txBusy, rxDone;
  logic [7:0] rxByte;

  serport_ctrl u_ctrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .busRdData(busRdData), .rxDone(rxDone),
    .rxByte(rxByte), .txBusy(txBusy), .strb(strb), .irqReq(irqReq),
    .irqVector(irqVector)
  );

  serport_dp #(.CLK_HZ(CLK_HZ), .SLOW_BAUD(SLOW_BAUD), .FAST_BAUD(FAST_BAUD)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .serIn(serIn), .serOut(serOut),
    .txBusy(txBusy), .rxDone(rxDone), .rxByte(rxByte)
  );
endmodule

// File: rtl/serport_chk.sv
module serport_chk
  import serport_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [1:0] busAddr,
  input logic       busRd,
  input logic [7:0] busRdData,
  input serStrb_t   strb,
  input logic       txBusy,
  input logic       serOut,
  input logic       rxDone,
  input logic       irqReq
);
  p_status_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (busAddr == ADDR_CTRL && !strb.portEn) |-> busRdData == 8'h00);

  p_start_low_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(txBusy) |-> !serOut);

  p_no_load_busy_r5: assert property (@(posedge clk) disable iff (rst)
    strb.txLoad |-> !txBusy);

  p_pop_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (busRd && busAddr == ADDR_DATA && !rxDone) |=> !irqReq);

  p_irq_enabled_r10: assert property (@(posedge clk) disable iff (rst)
    irqReq |-> strb.portEn);
endmodule

bind byte_serial_port serport_chk u_chk (
  .clk(clk), .rst(rst), .busAddr(busAddr), .busRd(busRd), .busRdData(busRdData),
  .strb(strb), .txBusy(txBusy), .serOut(serOut), .rxDone(rxDone), .irqReq(irqReq)
);

// File: tb/tb_byte_serial_port.sv
module tb_byte_serial_port;
  localparam int CLK_HZ = 3_072_000;
  localparam int SLOW   = 320;
  localparam int FAST   = 80;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] busAddr = '0;
  logic       busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       serIn = 1'b1;
  logic       serOut, irqReq;
  logic [7:0] irqVector;
  int nChk = 0, nFail = 0;

  always #4 clk = ~clk;

  byte_serial_port #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .busRdData(busRdData), .serIn(serIn), .serOut(serOut),
    .irqReq(irqReq), .irqVector(irqVector)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); busAddr = a; busRd = (a == 2'd0); #1 v = busRdData;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic sendRx(input logic [7:0] b, input int cpb);
    @(negedge clk); serIn = 1'b0;
    repeat (cpb) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      serIn = b[i];
      repeat (cpb) @(negedge clk);
    end
    serIn = 1'b1;
    repeat (cpb) @(negedge clk);
  endtask

  task automatic captureTx(input int cpb, output logic [7:0] b, output logic startBit, output logic stopBit);
    while (serOut) @(negedge clk);
    repeat (cpb / 2) @(negedge clk);
    startBit = serOut;
    for (int i = 0; i < 8; i++) begin
      repeat (cpb) @(negedge clk);
      b[i] = serOut;
    end
    repeat (cpb) @(negedge clk);
    stopBit = serOut;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 txd idle", {7'd0, serOut}, 8'h01);
    chk("R1 irq low", {7'd0, irqReq}, 8'h00);
    busRead(2'd1, v); chk("R1 status", v, 8'h00);
  endtask

  task automatic t_status;
    logic [7:0] v;
    busWrite(2'd1, 8'h80); busRead(2'd1, v); chk("R3 slow status", v, 8'h84);
    busWrite(2'd1, 8'hC0); busRead(2'd1, v); chk("R3 fast status", v, 8'hC4);
    busWrite(2'd1, 8'h80);
  endtask

  task automatic t_tx_slow;
    logic [7:0] v, b; logic s0, s1; logic sawLow;
    busWrite(2'd0, 8'hA5);
    busRead(2'd1, v); chk("R5 busy status", v, 8'h80);
    busWrite(2'd0, 8'h3C);
    captureTx(SLOW, b, s0, s1);
    chk("R4 slow start", {7'd0, s0}, 8'h00);
    chk("R4 slow data", b, 8'hA5);
    chk("R4 slow stop", {7'd0, s1}, 8'h01);
    repeat (400) @(negedge clk);
    busRead(2'd1, v); chk("R5 idle status", v, 8'h84);
    sawLow = 1'b0;
    repeat (700) begin @(negedge clk); if (!serOut) sawLow = 1'b1; end
    chk("R5 ignored write sent nothing", {7'd0, sawLow}, 8'h00);
  endtask

  task automatic t_tx_fast;
    logic [7:0] b; logic s0, s1;
    busWrite(2'd1, 8'hC0);
    busWrite(2'd0, 8'h5A);
    captureTx(FAST, b, s0, s1);
    chk("R4 fast start", {7'd0, s0}, 8'h00);
    chk("R4 fast data", b, 8'h5A);
    chk("R4 fast stop", {7'd0, s1}, 8'h01);
    repeat (200) @(negedge clk);
    busWrite(2'd1, 8'h80);
  endtask

  task automatic t_rx;
    logic [7:0] v;
    sendRx(8'h96, SLOW);
    busRead(2'd1, v); chk("R6 avail set", v, 8'h85);
    busRead(2'd0, v); chk("R6 byte", v, 8'h96);
    busRead(2'd1, v); chk("R6 avail cleared", v, 8'h84);
  endtask

  task automatic t_overrun;
    logic [7:0] v;
    sendRx(8'h11, SLOW);
    sendRx(8'h22, SLOW);
    busRead(2'd1, v); chk("R7 overrun flag", v, 8'h87);
    busRead(2'd0, v); chk("R7 first byte kept", v, 8'h11);
    busRead(2'd1, v); chk("R7 overrun sticky", v, 8'h86);
    busWrite(2'd1, 8'hA0);
    busRead(2'd1, v); chk("R8 overrun cleared", v, 8'h84);
  endtask

  task automatic t_false_start;
    logic [7:0] v;
    @(negedge clk); serIn = 1'b0;
    repeat (100) @(negedge clk);
    serIn = 1'b1;
    repeat (4000) @(negedge clk);
    busRead(2'd1, v); chk("R9 glitch rejected", v, 8'h84);
    sendRx(8'h3C, SLOW);
    busRead(2'd0, v); chk("R9 next frame ok", v, 8'h3C);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    busWrite(2'd2, 8'h00); busWrite(2'd3, 8'hF0);
    sendRx(8'h77, SLOW);
    chk("R10 masked irq", {7'd0, irqReq}, 8'h00);
    busWrite(2'd2, 8'h04);
    @(negedge clk);
    chk("R10 irq raised", {7'd0, irqReq}, 8'h01);
    chk("R10 vector", irqVector, 8'hF3);
    busWrite(2'd3, 8'hFE);
    @(negedge clk);
    chk("R10 vector wrap", irqVector, 8'h01);
    busWrite(2'd1, 8'h00);
    busRead(2'd1, v); chk("R2 disabled status", v, 8'h00);
    chk("R10 irq off when disabled", {7'd0, irqReq}, 8'h00);
    busWrite(2'd1, 8'h80);
    @(negedge clk);
    chk("R10 irq back", {7'd0, irqReq}, 8'h01);
    busRead(2'd0, v); chk("R6 irq byte", v, 8'h77);
    @(negedge clk);
    chk("R10 irq cleared by read", {7'd0, irqReq}, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_status;
    t_tx_slow;
    t_tx_fast;
    t_rx;
    t_overrun;
    t_false_start;
    t_irq;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule